// File: doc/BRIEF.md
# Accumulator-Processor Opcode Decoder

This block is a purely combinational decoder for the first byte of an instruction on a classic 8-bit accumulator machine. From that one byte it produces everything the rest of the core needs before any operand byte arrives:

- an instruction class;
- the two 3-bit register selects and the 2-bit register-pair select;
- a flag for a memory operand addressed through the HL pair;
- the condition field and a flag for conditional flow instructions;
- a flag that switches the pair field to its stack meaning;
- the total instruction length;
- an illegal-opcode flag.

The fetch sequencer uses the length to decide how many operand bytes to collect. The datapath uses the class and the selects to steer registers and the ALU.

Internally, a classifier turns the group (bits 7:6) and the low field (bits 2:0) into a set of one-hot strobes. A field stage then turns those strobes into the class code, the length and the memory-operand flag. No state is held.

Top module: `opcodeDecoder`

## Requirements
- R1: For bits 7:6 = 01, every opcode except 0x76 has class 1 (move) and length 1. memOperand is 1 exactly when bits 5:3 or bits 2:0 equal 6.
- R2: Opcode 0x76 (halt) has class 14 (control), length 1, memOperand 0 and illegalOp 0.
- R3: For bits 7:6 = 10, the class is 3 (ALU with register or memory source) and the length is 1. memOperand is 1 exactly when bits 2:0 equal 6. The ALU operation is bits 5:3, ordered add, add-with-carry, subtract, subtract-with-borrow, and, xor, or, compare.
- R4: For every opcode, the register and pair selects are copies of fixed opcode bits. dstSel is bits 5:3, srcSel is bits 2:0, pairSel is bits 5:4 and condCode is bits 5:3. Register codes 0 to 7 mean B, C, D, E, H, L, memory-at-HL and A.
- R5: pairIsAf is 1 only when bits 7:6 = 11, bit 3 = 0 and bits 2:0 are 001 (pop) or 101 (push). It then selects AF instead of SP for pair code 3.
- R6: instLen is 2 for the 8-bit immediate forms:
  - move immediate: 00yyy110;
  - ALU immediate: 11yyy110;
  - port output 0xD3 and port input 0xDB.
- R7: instLen is 3 for the 16-bit forms:
  - pair load immediate: 00pp0001;
  - the direct loads and stores 0x22, 0x2A, 0x32 and 0x3A;
  - jump 0xC3 and call 0xCD;
  - conditional jump 11ccc010 and conditional call 11ccc100.
  - Every other opcode has length 1.
- R8: The opcodes 0x08, 0x10, 0x18, 0x28, 0x38, 0xCB, 0xD9, 0xDD, 0xED and 0xFD are illegal. They give illegalOp 1, class 0 and length 1. All other opcodes give illegalOp 0.
- R9: isConditional is 1 exactly for bits 7:6 = 11 with bits 2:0 equal to 000 (return), 010 (jump) or 100 (call).
- R10: The remaining class codes are:
  - 2: move immediate.
  - 4: ALU immediate.
  - 5: 8-bit increment and decrement, 00yyy100 and 00yyy101.
  - 6: 16-bit pair operations, 00ppq001 and 00ppq011.
  - 7: indirect and direct load and store, 00yyy010.
  - 8: stack operations, namely push, pop, 0xE3 and 0xF9.
  - 9: jumps, namely 0xC3, conditional jumps and 0xE9.
  - 10: calls, namely 0xCD, conditional calls and restarts 11nnn111.
  - 11: returns, namely 0xC9 and conditional returns.
  - 12: port I/O, 0xD3 and 0xDB.
  - 13: accumulator operations, 00yyy111.
  - 14: control, namely 0x00, 0x20, 0x30, 0x76, 0xF3 and 0xFB.
  - 15: register exchange, 0xEB.
- R11: For 00yyy100, 00yyy101 and 00yyy110, memOperand is 1 exactly when bits 5:3 equal 6. memOperand is 0 for every opcode that has no register field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 8 | First instruction byte |
| instClass | output | 4 | Instruction class code |
| dstSel | output | 3 | Destination register select (bits 5:3) |
| srcSel | output | 3 | Source register select (bits 2:0) |
| pairSel | output | 2 | Register-pair select (bits 5:4) |
| pairIsAf | output | 1 | Pair code 3 means AF rather than SP |
| memOperand | output | 1 | A used register field addresses memory at HL |
| condCode | output | 3 | Condition or restart number (bits 5:3) |
| isConditional | output | 1 | Conditional return, jump or call |
| instLen | output | 2 | Instruction length in bytes (1 to 3) |
| illegalOp | output | 1 | Opcode is undefined |

## Verification
Every output is combinational, so each result is due in the same cycle the opcode is applied, with no register in the path. The bench drives a new opcode on the falling clock edge. It samples all outputs one nanosecond later, well before the next rising edge. All 256 opcodes are swept, and the expected class, length and flags for each come from an explicit opcode-pattern model in the bench.

// File: rtl/decodePkg.sv
package decodePkg;

  localparam int OPCODE_W = 8;
  localparam int REG_W    = 3;
  localparam int PAIR_W   = 2;
  localparam int CLASS_W  = 4;
  localparam int LEN_W    = 2;
  localparam logic [REG_W-1:0] MEM_REG_CODE = 3'd6;

  typedef enum logic [CLASS_W-1:0] {
    CLS_ILLEGAL  = 4'd0,
    CLS_MOVE     = 4'd1,
    CLS_MOVEIMM  = 4'd2,
    CLS_ALU      = 4'd3,
    CLS_ALUIMM   = 4'd4,
    CLS_INCDEC   = 4'd5,
    CLS_PAIR16   = 4'd6,
    CLS_LDST     = 4'd7,
    CLS_STACK    = 4'd8,
    CLS_JUMP     = 4'd9,
    CLS_CALL     = 4'd10,
    CLS_RETURN   = 4'd11,
    CLS_PORTIO   = 4'd12,
    CLS_ACCUM    = 4'd13,
    CLS_CONTROL  = 4'd14,
    CLS_EXCHANGE = 4'd15
  } instClassE;

  typedef struct packed {
    logic isMove;
    logic isMvi;
    logic isAluReg;
    logic isAluImm;
    logic isIncDec;
    logic isPair16;
    logic isLdSt;
    logic isStack;
    logic isJump;
    logic isCall;
    logic isRet;
    logic isPortIo;
    logic isAccum;
    logic isControl;
    logic isExchange;
    logic isIllegal;
    logic isCond;
    logic isShort;
    logic isLong;
    logic usesDst;
    logic usesSrc;
    logic pairAf;
  } decodeStrobesT;

endpackage

// File: rtl/decodeCtrl.sv
module decodeCtrl
  import decodePkg::*;
(
  input  logic [OPCODE_W-1:0] opcode,
  output decodeStrobesT       strobes
);

  logic [1:0]       grp;
  logic [REG_W-1:0] yField;
  logic [REG_W-1:0] zField;
  logic [1:0]       pField;
  logic             qBit;

  assign grp    = opcode[7:6];
  assign yField = opcode[5:3];
  assign zField = opcode[2:0];
  assign pField = opcode[5:4];
  assign qBit   = opcode[3];

  always_comb begin
    strobes = '0;
    unique case (grp)
      2'b00: begin
        unique case (zField)
          3'd0: begin
            if (yField == 3'd0 || yField == 3'd4 || yField == 3'd6)
              strobes.isControl = 1'b1;
            else
              strobes.isIllegal = 1'b1;
          end
          3'd1: begin
            strobes.isPair16 = 1'b1;
            strobes.isLong   = ~qBit;
          end
          3'd2: begin
            strobes.isLdSt  = 1'b1;
            strobes.isLong  = pField[1];
          end
          3'd3: strobes.isPair16 = 1'b1;
          3'd4, 3'd5: begin
            strobes.isIncDec = 1'b1;
            strobes.usesDst  = 1'b1;
          end
          3'd6: begin
            strobes.isMvi   = 1'b1;
            strobes.usesDst = 1'b1;
            strobes.isShort = 1'b1;
          end
          default: strobes.isAccum = 1'b1;
        endcase
      end
      2'b01: begin
        if (yField == MEM_REG_CODE && zField == MEM_REG_CODE) begin
          strobes.isControl = 1'b1;
        end else begin
          strobes.isMove  = 1'b1;
          strobes.usesDst = 1'b1;
          strobes.usesSrc = 1'b1;
        end
      end
      2'b10: begin
        strobes.isAluReg = 1'b1;
        strobes.usesSrc  = 1'b1;
      end
      default: begin
        unique case (zField)
          3'd0: begin
            strobes.isRet  = 1'b1;
            strobes.isCond = 1'b1;
          end
          3'd1: begin
            if (!qBit) begin
              strobes.isStack = 1'b1;
              strobes.pairAf  = 1'b1;
            end else begin
              unique case (pField)
                2'd0: strobes.isRet     = 1'b1;
                2'd1: strobes.isIllegal = 1'b1;
                2'd2: strobes.isJump    = 1'b1;
                default: strobes.isStack = 1'b1;
              endcase
            end
          end
          3'd2: begin
            strobes.isJump = 1'b1;
            strobes.isCond = 1'b1;
            strobes.isLong = 1'b1;
          end
          3'd3: begin
            unique case (yField)
              3'd0: begin
                strobes.isJump = 1'b1;
                strobes.isLong = 1'b1;
              end
              3'd1: strobes.isIllegal = 1'b1;
              3'd2, 3'd3: begin
                strobes.isPortIo = 1'b1;
                strobes.isShort  = 1'b1;
              end
              3'd4: strobes.isStack    = 1'b1;
              3'd5: strobes.isExchange = 1'b1;
              default: strobes.isControl = 1'b1;
            endcase
          end
          3'd4: begin
            strobes.isCall = 1'b1;
            strobes.isCond = 1'b1;
            strobes.isLong = 1'b1;
          end
          3'd5: begin
            if (!qBit) begin
              strobes.isStack = 1'b1;
              strobes.pairAf  = 1'b1;
            end else if (pField == 2'd0) begin
              strobes.isCall = 1'b1;
              strobes.isLong = 1'b1;
            end else begin
              strobes.isIllegal = 1'b1;
            end
          end
          3'd6: begin
            strobes.isAluImm = 1'b1;
            strobes.isShort  = 1'b1;
          end
          default: strobes.isCall = 1'b1;
        endcase
      end
    endcase
  end

endmodule

// File: rtl/decodeData.sv
module decodeData
  import decodePkg::*;
(
  input  logic [OPCODE_W-1:0] opcode,
  input  decodeStrobesT       strobes,
  output logic [CLASS_W-1:0]  instClass,
  output logic [REG_W-1:0]    dstSel,
  output logic [REG_W-1:0]    srcSel,
  output logic [PAIR_W-1:0]   pairSel,
  output logic                pairIsAf,
  output logic                memOperand,
  output logic [REG_W-1:0]    condCode,
  output logic                isConditional,
  output logic [LEN_W-1:0]    instLen,
  output logic                illegalOp
);

  localparam int CLASS_SRC_N = 15;

  logic [CLASS_SRC_N-1:0] classHit;
  instClassE              classOrder [CLASS_SRC_N];
  instClassE              classSel;

  assign classHit = {strobes.isExchange, strobes.isControl, strobes.isAccum,
                     strobes.isPortIo, strobes.isRet, strobes.isCall,
                     strobes.isJump, strobes.isStack, strobes.isLdSt,
                     strobes.isPair16, strobes.isIncDec, strobes.isAluImm,
                     strobes.isAluReg, strobes.isMvi, strobes.isMove};

  // Class code k+1 belongs to strobe bit k.
  for (genvar k = 0; k < CLASS_SRC_N; k++) begin : gClassMap
    assign classOrder[k] = instClassE'(k + 1);
  end

  always_comb begin
    classSel = CLS_ILLEGAL;
    for (int k = 0; k < CLASS_SRC_N; k++) begin
      if (classHit[k]) classSel = classOrder[k];
    end
  end

  assign dstSel   = opcode[5:3];
  assign srcSel   = opcode[2:0];
  assign pairSel  = opcode[5:4];
  assign condCode = opcode[5:3];

  assign instClass     = strobes.isIllegal ? CLS_ILLEGAL : classSel;
  assign pairIsAf      = strobes.pairAf;
  assign isConditional = strobes.isCond;
  assign illegalOp     = strobes.isIllegal;

  assign memOperand = (strobes.usesDst && dstSel == MEM_REG_CODE) ||
                      (strobes.usesSrc && srcSel == MEM_REG_CODE);

  always_comb begin
    if (strobes.isLong)       instLen = LEN_W'(3);
    else if (strobes.isShort) instLen = LEN_W'(2);
    else                      instLen = LEN_W'(1);
  end

endmodule

// File: rtl/opcodeDecoder.sv
module opcodeDecoder
  import decodePkg::*;
(
  input  logic [7:0] opcode,
  output logic [3:0] instClass,
  output logic [2:0] dstSel,
  output logic [2:0] srcSel,
  output logic [1:0] pairSel,
  output logic       pairIsAf,
  output logic       memOperand,
  output logic [2:0] condCode,
  output logic       isConditional,
  output logic [1:0] instLen,
  output logic       illegalOp
);

  decodeStrobesT strobes;

  decodeCtrl uCtrl (
    .opcode  (opcode),
    .strobes (strobes)
  );

  decodeData uData (
    .opcode        (opcode),
    .strobes       (strobes),
    .instClass     (instClass),
    .dstSel        (dstSel),
    .srcSel        (srcSel),
    .pairSel       (pairSel),
    .pairIsAf      (pairIsAf),
    .memOperand    (memOperand),
    .condCode      (condCode),
    .isConditional (isConditional),
    .instLen       (instLen),
    .illegalOp     (illegalOp)
  );

endmodule

// File: rtl/opcodeDecoderChecker.sv
module opcodeDecoderChecker (
  input logic [7:0] opcode,
  input logic [3:0] instClass,
  input logic [2:0] dstSel,
  input logic [2:0] srcSel,
  input logic [1:0] pairSel,
  input logic       pairIsAf,
  input logic       memOperand,
  input logic [2:0] condCode,
  input logic       isConditional,
  input logic [1:0] instLen,
  input logic       illegalOp
);

  always_comb begin
    if (!$isunknown(opcode)) begin
      AST_MOVE_CLASS: assert (!(opcode[7:6] == 2'b01 && opcode != 8'h76) || (instClass == 4'd1 && instLen == 2'd1)); // R1
      AST_HALT_SLOT: assert (opcode != 8'h76 || (instClass == 4'd14 && !memOperand && !illegalOp)); // R2
      AST_ALU_MEM: assert (opcode[7:6] != 2'b10 || (memOperand == (opcode[2:0] == 3'd6))); // R3
      AST_FIELD_COPY: assert (dstSel == opcode[5:3] && srcSel == opcode[2:0] && pairSel == opcode[5:4]); // R4
      AST_PAIR_AF_STACK: assert (!pairIsAf || instClass == 4'd8); // R5
      AST_LEN_RANGE: assert (instLen != 2'd0); // R6
      AST_ILLEGAL_SHAPE: assert (!illegalOp || (instClass == 4'd0 && instLen == 2'd1 && !memOperand)); // R8
      AST_COND_FLOW: assert (!isConditional || instClass inside {4'd9, 4'd10, 4'd11}); // R9
    end
  end

endmodule

bind opcodeDecoder opcodeDecoderChecker chk (.*);

// File: tb/opcodeDecoder_test.sv
module opcodeDecoder_test;

  logic       clk = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic [3:0] instClass;
  logic [2:0] dstSel;
  logic [2:0] srcSel;
  logic [1:0] pairSel;
  logic       pairIsAf;
  logic       memOperand;
  logic [2:0] condCode;
  logic       isConditional;
  logic [1:0] instLen;
  logic       illegalOp;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  opcodeDecoder uut (
    .opcode        (opcode),
    .instClass     (instClass),
    .dstSel        (dstSel),
    .srcSel        (srcSel),
    .pairSel       (pairSel),
    .pairIsAf      (pairIsAf),
    .memOperand    (memOperand),
    .condCode      (condCode),
    .isConditional (isConditional),
    .instLen       (instLen),
    .illegalOp     (illegalOp)
  );

  task automatic check(input bit ok, input string req, input logic [7:0] op,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s op=%02h actual=%0d expected=%0d", req, op, act, exp);
    end
  endtask

  function automatic bit expIllegal(input logic [7:0] op);
    return op inside {8'h08, 8'h10, 8'h18, 8'h28, 8'h38,
                      8'hCB, 8'hD9, 8'hDD, 8'hED, 8'hFD};
  endfunction

  function automatic int expClass(input logic [7:0] op);
    if (expIllegal(op)) return 0;
    if (op inside {8'h00, 8'h20, 8'h30, 8'h76, 8'hF3, 8'hFB}) return 14;
    if (op == 8'hEB) return 15;
    if (op inside {8'hD3, 8'hDB}) return 12;
    if (op inside {8'hE3, 8'hF9}) return 8;
    if (op inside {8'hC3, 8'hE9}) return 9;
    if (op == 8'hCD) return 10;
    if (op == 8'hC9) return 11;
    casez (op)
      8'b01??????: return 1;
      8'b10??????: return 3;
      8'b00???110: return 2;
      8'b11???110: return 4;
      8'b00???10?: return 5;
      8'b00???0?1: return 6;
      8'b00???010: return 7;
      8'b00???111: return 13;
      8'b11??0?01: return 8;
      8'b11???010: return 9;
      8'b11???100: return 10;
      8'b11???111: return 10;
      8'b11???000: return 11;
      default:     return -1;
    endcase
  endfunction

  function automatic int expLen(input logic [7:0] op);
    if (op inside {8'hD3, 8'hDB}) return 2;
    if (op inside {8'h22, 8'h2A, 8'h32, 8'h3A, 8'hC3, 8'hCD}) return 3;
    casez (op)
      8'b00???110, 8'b11???110: return 2;
      8'b00??0001, 8'b11???010, 8'b11???100: return 3;
      default: return 1;
    endcase
  endfunction

  function automatic bit expMem(input logic [7:0] op);
    if (op == 8'h76) return 1'b0;
    if (op[7:6] == 2'b01) return (op[5:3] == 3'd6) || (op[2:0] == 3'd6);
    if (op[7:6] == 2'b10) return op[2:0] == 3'd6;
    if (op[7:6] == 2'b00 && op[2:0] inside {3'd4, 3'd5, 3'd6}) return op[5:3] == 3'd6;
    return 1'b0;
  endfunction

  initial begin
    // Power-up value of the input: opcode 0x00 is the no-operation control code.
    #1;
    check(instClass == 4'd14, "R10 initial", opcode, instClass, 14);
    check(instLen == 2'd1, "R7 initial", opcode, instLen, 1);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      opcode = 8'(i);
      #1;
      if (opcode[7:6] == 2'b01 && opcode != 8'h76)
        check(instClass == 4'd1, "R1 move class", opcode, instClass, 1);
      else if (opcode == 8'h76)
        check(instClass == 4'd14 && !illegalOp, "R2 halt", opcode, instClass, 14);
      else if (opcode[7:6] == 2'b10)
        check(instClass == 4'd3, "R3 alu class", opcode, instClass, 3);
      else
        check(int'(instClass) == expClass(opcode), "R10 class", opcode, instClass, expClass(opcode));
      check(dstSel == opcode[5:3] && srcSel == opcode[2:0], "R4 reg selects",
            opcode, {dstSel, srcSel}, opcode[5:0]);
      check(pairSel == opcode[5:4] && condCode == opcode[5:3], "R4 pair/cond",
            opcode, {pairSel, condCode}, {opcode[5:4], opcode[5:3]});
      check(pairIsAf == (opcode[7:6] == 2'b11 && !opcode[3] && opcode[2:0] inside {3'd1, 3'd5}),
            "R5 pairIsAf", opcode, pairIsAf, !pairIsAf);
      if (expLen(opcode) == 2)
        check(instLen == 2'd2, "R6 length", opcode, instLen, 2);
      else
        check(int'(instLen) == expLen(opcode), "R7 length", opcode, instLen, expLen(opcode));
      check(illegalOp == expIllegal(opcode), "R8 illegal", opcode, illegalOp, expIllegal(opcode));
      check(isConditional == (opcode[7:6] == 2'b11 && opcode[2:0] inside {3'd0, 3'd2, 3'd4}),
            "R9 conditional", opcode, isConditional, !isConditional);
      if (opcode[7:6] == 2'b00)
        check(memOperand == expMem(opcode), "R11 memOperand", opcode, memOperand, expMem(opcode));
      else if (opcode[7:6] == 2'b11)
        check(memOperand == 1'b0, "R11 no register field", opcode, memOperand, 0);
      else if (opcode[7:6] == 2'b10)
        check(memOperand == expMem(opcode), "R3 memOperand", opcode, memOperand, expMem(opcode));
      else
        check(memOperand == expMem(opcode), "R1 memOperand", opcode, memOperand, expMem(opcode));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule